// File: doc/BRIEF.md
# Density-Controlled Random Dot Stream Generator

This block emits one pseudo-random bit per pixel clock, for use as the dot layer of a random-dot display. A 24-stage linear feedback shift register supplies the noise. The low register stages form a window of eight taps. An 8-bit mask picks which of those taps are ANDed together to make the dot. Each extra selected tap halves the share of lit pixels.

A frame-length counter is loaded with a preload value and counts up to its all-ones state. On that cycle it wraps, reloads the preload value and, when re-seeding is enabled, returns the shift register to its seed. With the count length set to exactly one screen of pixels, every frame shows the same pattern, so the field is static. One extra pixel per frame makes the field drift right by one pixel per frame. One extra line of pixels makes it drift down by one line per frame. Shortening the count moves the field the opposite way. With re-seeding disabled, the generator free-runs and the display shows snow. A new mask or preload value only takes effect at a frame boundary, so no frame is torn.

Top module: `dot_stream_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `dot_o` becomes 0, the generator state becomes the seed, the counter loads `frame_preload_i` and the active mask loads `dot_mask_i`.
- R2: The generator shifts once per clock toward its most significant stage. The new bit 0 is the XOR of stages 23, 22, 21 and 16, so the state is never zero and, left free, repeats after 2^24-1 steps.
- R3: `dot_o` is registered. One clock after the generator holds state S, `dot_o` is 1 exactly when every stage i (0 to 7) whose active-mask bit i is 1 holds a 1 in S. An all-zero mask therefore gives a constant 1.
- R4: A mask of 0x01 lights close to half of the pixels. A mask of 0xFF lights close to one pixel in 256.
- R5: The counter adds one per clock. At the clock edge where it holds all ones, it loads `frame_preload_i` instead. A frame therefore lasts 2^23 minus the preload value clocks.
- R6: With `reseed_en_i` high at a wrap, the generator returns to the seed, so every frame repeats the same dot sequence exactly.
- R7: With `reseed_en_i` low at a wrap, the generator keeps stepping and is not re-seeded.
- R8: `frame_preload_i` is sampled only at a wrap. Changes during a frame do not alter that frame's length.
- R9: `dot_mask_i` is copied into the active mask only at a wrap. The first dot of the new frame is the first to use it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| dot_mask_i | input | 8 | Tap selection mask that sets dot density |
| frame_preload_i | input | 23 | Counter start value; frame length is 2^23 minus this |
| reseed_en_i | input | 1 | 1: re-seed at each wrap (static or drifting field); 0: free-run (snow) |
| dot_o | output | 1 | Registered dot bit |

## Verification
A corrupted shift-register stage or feedback tap shows at `dot_o` within a few clocks. Once the bad bit reaches the tap window, the stream departs from the reference sequence. A counter that reloads one cycle early or late does not show up until the frame boundary. There, the next frame's dots come out shifted against the expected restart, so every dot after the wrap can miscompare. A mask latched at the wrong time shows up as a density or pattern mismatch in the first pixels of the frame.

// File: rtl/dotgen_pkg.sv
package dotgen_pkg;
  localparam int unsigned LFSR_W_DEF = 24;
  localparam int unsigned MASK_W_DEF = 8;
  localparam int unsigned CNT_W_DEF  = 23;
  // feedback taps: stages 23, 22, 21, 16 (maximal length for 24 stages)
  localparam logic [LFSR_W_DEF-1:0] TAPS_DEF = 24'hE10000;
  localparam logic [LFSR_W_DEF-1:0] SEED_DEF = 24'h9E3779;
endpackage

// File: rtl/dotgen_lfsr.sv
module dotgen_lfsr #(
  parameter int unsigned        SW   = dotgen_pkg::LFSR_W_DEF,
  parameter logic [SW-1:0]      TAPS = dotgen_pkg::TAPS_DEF,
  parameter logic [SW-1:0]      SEED = dotgen_pkg::SEED_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reseed,
  output logic [SW-1:0] state
);
  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (rst || reseed) state <= SEED;
    else               state <= {state[SW-2:0], fb};
  end
endmodule

// File: rtl/dotgen_density.sv
module dotgen_density #(
  parameter int unsigned MW = dotgen_pkg::MASK_W_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [MW-1:0] mask_in,
  input  logic [MW-1:0] taps,
  output logic [MW-1:0] mask_act,
  output logic          dot
);
  logic [MW-1:0] term;

  // an unselected tap contributes a constant 1 to the AND
  for (genvar i = 0; i < MW; i++) begin : g_term
    assign term[i] = taps[i] | ~mask_act[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_act <= mask_in;
      dot      <= 1'b0;
    end else begin
      dot <= &term;
      if (load) mask_act <= mask_in;
    end
  end
endmodule

// File: rtl/dotgen_frame_ctr.sv
module dotgen_frame_ctr #(
  parameter int unsigned CW = dotgen_pkg::CNT_W_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] preload,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  localparam logic [CW-1:0] LAST = {CW{1'b1}};

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || wrap) cnt <= preload;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dot_stream_gen.sv
module dot_stream_gen #(
  parameter int unsigned          CNT_W  = dotgen_pkg::CNT_W_DEF,
  parameter int unsigned          LFSR_W = dotgen_pkg::LFSR_W_DEF,
  parameter int unsigned          MASK_W = dotgen_pkg::MASK_W_DEF,
  parameter logic [LFSR_W-1:0]    TAPS   = dotgen_pkg::TAPS_DEF,
  parameter logic [LFSR_W-1:0]    SEED   = dotgen_pkg::SEED_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MASK_W-1:0] dot_mask_i,
  input  logic [CNT_W-1:0]  frame_preload_i,
  input  logic              reseed_en_i,
  output logic              dot_o
);
  logic [CNT_W-1:0]  frame_cnt;
  logic              frame_wrap;
  logic              reseed;
  logic [LFSR_W-1:0] lfsr_state;
  logic [MASK_W-1:0] mask_live;

  assign reseed = frame_wrap & reseed_en_i;

  dotgen_frame_ctr #(.CW(CNT_W)) i_ctr (
    .clk     (clk),
    .rst     (rst),
    .preload (frame_preload_i),
    .cnt     (frame_cnt),
    .wrap    (frame_wrap)
  );

  dotgen_lfsr #(.SW(LFSR_W), .TAPS(TAPS), .SEED(SEED)) i_lfsr (
    .clk    (clk),
    .rst    (rst),
    .reseed (reseed),
    .state  (lfsr_state)
  );

  dotgen_density #(.MW(MASK_W)) i_dens (
    .clk      (clk),
    .rst      (rst),
    .load     (frame_wrap),
    .mask_in  (dot_mask_i),
    .taps     (lfsr_state[MASK_W-1:0]),
    .mask_act (mask_live),
    .dot      (dot_o)
  );
endmodule

// File: rtl/dot_stream_gen_chk.sv
module dot_stream_gen_chk #(
  parameter int unsigned       CNT_W  = 23,
  parameter int unsigned       LFSR_W = 24,
  parameter int unsigned       MASK_W = 8,
  parameter logic [LFSR_W-1:0] SEED   = '1
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [CNT_W-1:0]  preload,
  input logic [MASK_W-1:0] mask_in,
  input logic [CNT_W-1:0]  cnt,
  input logic              wrap,
  input logic [LFSR_W-1:0] state,
  input logic [MASK_W-1:0] mask_act,
  input logic              dot
);
  a_r1_dot_cleared: assert property (@(posedge clk) rst |=> !dot);

  a_r2_state_nonzero: assert property (@(posedge clk) disable iff (rst)
    state != '0);

  a_r3_empty_mask_lit: assert property (@(posedge clk) disable iff (rst)
    (mask_act == '0) |=> dot);

  a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> cnt == CNT_W'($past(cnt) + 1'b1));

  a_r8_reload_preload: assert property (@(posedge clk) disable iff (rst)
    wrap |=> cnt == $past(preload));

  a_r6_reseed_at_wrap: assert property (@(posedge clk) disable iff (rst)
    (wrap && en) |=> state == SEED);

  a_r9_mask_held: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(mask_act));

  a_r9_mask_loaded: assert property (@(posedge clk) disable iff (rst)
    wrap |=> mask_act == $past(mask_in));
endmodule

bind dot_stream_gen dot_stream_gen_chk #(
  .CNT_W(CNT_W), .LFSR_W(LFSR_W), .MASK_W(MASK_W), .SEED(SEED)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (reseed_en_i),
  .preload  (frame_preload_i),
  .mask_in  (dot_mask_i),
  .cnt      (frame_cnt),
  .wrap     (frame_wrap),
  .state    (lfsr_state),
  .mask_act (mask_live),
  .dot      (dot_o)
);

// File: tb/test_dot_stream_gen.sv
`timescale 1ns/1ps
module test_dot_stream_gen;
  localparam int unsigned CW = 23;
  localparam logic [23:0] B_SEED = 24'h3C96A5;
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] mask = 8'h01;
  logic [CW-1:0] preload = '0;
  logic en = 1'b1;
  logic dot;

  int vecs = 0;
  int errs = 0;
  string req = "R1";
  bit done = 1'b0;

  logic [23:0]   m_state;
  logic [CW-1:0] m_cnt;
  logic [7:0]    m_mask;
  logic          m_dot;
  logic          cap [0:1199];

  always #2.5 clk = ~clk;

  dot_stream_gen #(.SEED(B_SEED)) i_dot_stream_gen (
    .clk(clk), .rst(rst), .dot_mask_i(mask), .frame_preload_i(preload),
    .reseed_en_i(en), .dot_o(dot)
  );

  function automatic logic [23:0] nxt(input logic [23:0] s);
    return {s[22:0], s[23] ^ s[22] ^ s[21] ^ s[16]};
  endfunction

  function automatic logic fdot(input logic [23:0] s, input logic [7:0] m);
    return &(s[7:0] | ~m);
  endfunction

  function automatic logic [CW-1:0] len2pre(input int unsigned len);
    return CW'((1 << CW) - len);
  endfunction

  task automatic check(input logic act, input logic exp, input string r);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s at %0t: dot=%0b expected %0b", r, $time, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst) begin
      m_state = B_SEED; m_cnt = preload; m_mask = mask; m_dot = 1'b0;
    end else begin
      m_dot = fdot(m_state, m_mask);
      if (m_cnt == TOP) begin
        m_cnt = preload; m_mask = mask;
        m_state = en ? B_SEED : nxt(m_state);
      end else begin
        m_cnt = m_cnt + 1'b1;
        m_state = nxt(m_state);
      end
    end
    @(negedge clk);
    check(dot, m_dot, req);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset(input logic [7:0] m, input int unsigned len, input logic e);
    req = "R1";
    rst = 1'b1; mask = m; preload = len2pre(len); en = e;
    step(); step();
    rst = 1'b0;
  endtask

  initial begin
    #(190000 * 5);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run did not end, got hang expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    int ones;
    r = $urandom(32'd2024);
    @(negedge clk);

    // R1 reset state, then R2 sequence from the seed
    do_reset(8'h01, 600, 1'b1);
    req = "R2";
    for (int k = 0; k < 1200; k++) begin
      step();
      cap[k] = dot;
    end
    // R6 identical frames with re-seeding on
    for (int k = 0; k < 600; k++) check(cap[k + 600], cap[k], "R6");

    // R8 preload changed mid-frame
    req = "R8";
    run(100);
    preload = len2pre(400);
    run(1300);

    // R9 mask changed mid-frame
    req = "R9";
    run(150);
    mask = 8'h03;
    run(1000);

    // R7 free run, no re-seed
    req = "R7";
    en = 1'b0;
    run(3000);

    // R3 empty mask gives constant 1 after the next wrap
    req = "R3";
    en = 1'b1;
    mask = 8'h00;
    run(500);
    for (int k = 0; k < 300; k++) begin
      step();
      check(dot, 1'b1, "R3");
    end

    // R5 random frame lengths, masks, re-seed modes
    for (int s = 0; s < 30; s++) begin
      req = "R5";
      mask = 8'($urandom) & 8'($urandom);
      preload = len2pre(100 + ($urandom % 600));
      en = 1'($urandom);
      run(200 + int'($urandom % 400));
    end

    // R4 density with mask 0x01
    do_reset(8'h01, 5000, 1'b0);
    req = "R4";
    ones = 0;
    for (int k = 0; k < 40000; k++) begin
      step();
      ones += int'(dot);
    end
    vecs++;
    if (ones < 18800 || ones > 21200) begin
      errs++;
      $display("FAIL R4: ones=%0d expected about 20000", ones);
    end

    // R4 density with mask 0xFF
    do_reset(8'hFF, 5000, 1'b0);
    req = "R4";
    ones = 0;
    for (int k = 0; k < 60000; k++) begin
      step();
      ones += int'(dot);
    end
    vecs++;
    if (ones < 140 || ones > 340) begin
      errs++;
      $display("FAIL R4: ones=%0d expected about 234", ones);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule